// File: doc/BRIEF.md
# Port I/O Instruction Executor

This block runs the single-transfer port input and output instructions of an 8-bit CPU core. The sequencer hands it the opcode bytes of one instruction and a snapshot of the register file. The block decodes the opcode and forms the 16-bit port address. It performs one read or one write on the I/O bus through a request/acknowledge handshake. Once the access ends and the instruction's cycle budget has run out, it reports completion. At that moment it also gives any register and flag write-back as a one-cycle pulse.

Two families of opcode are handled. The immediate-port form has a port number in its second byte and uses the accumulator both as the upper address byte and as the data. The prefixed register-port form addresses the port with B in the upper byte and C in the lower byte. It moves data to or from a register that a 3-bit code selects. An input in this form also recomputes the sign, zero and parity flags. Any opcode the block does not handle is refused with a one-cycle "not mine" pulse and causes no side effects.

Top module: `port_io_exec`

## Requirements
- R1: Opcode 0xDB with immediate byte n performs a port read at address {A, n}. The byte read is written back with `wb_sel` = 3'b111 (A). `flag_we` stays low.
- R2: Opcode 0xD3 with immediate byte n performs a port write of A to address {A, n}. Neither `wb_en` nor `flag_we` is raised.
- R3: Prefix 0xED followed by a second byte 01rrr000 performs a port read at address {B, C}. For r other than 110, the byte read is written back with `wb_sel` = r. The codes are B=000, C=001, D=010, E=011, H=100, L=101, A=111.
- R4: Prefix 0xED followed by 01rrr001 performs a port write to address {B, C}. The data is the register that code r selects. Code 110 sends the flag register.
- R5: A register-port read writes back flags laid out as S=bit7, Z=bit6, H=bit4, P/V=bit2, N=bit1, C=bit0. S is data bit 7. Z is set when the data is zero. P/V is set when the data has an even number of ones. H and N are cleared. C and bits 5 and 3 keep their values from `reg_f`.
- R6: A register-port read with r=110 raises `flag_we` but leaves `wb_en` low.
- R7: `done` is a one-cycle pulse. If the acknowledge comes at the first sampling edge after the strobe appears, `done` is high in the cycle after the 11th clock edge for the immediate forms, counting the edge that accepts `start` as the first. The register-port forms take 12 edges. When the acknowledge is late, `done` follows the edge that samples it by one cycle.
- R8: The strobe, `io_addr` and `io_wdata` hold steady until the edge that samples `io_ack`. The strobe is low in the cycle after that edge.
- R9: An opcode that matches none of the handled forms gives a one-cycle `not_mine` pulse in the cycle after the accepting edge. It produces no strobe, no `done` and no write-back.
- R10: Each instruction makes exactly one contiguous access. `io_rd` and `io_wr` are never high together.
- R11: A `start` that arrives while an instruction is in progress is ignored.
- R12: During and right after reset, every strobe and pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode bytes and register snapshot are valid |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second byte (immediate port or prefixed opcode) |
| reg_a | input | 8 | Accumulator |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_h | input | 8 | Register H |
| reg_l | input | 8 | Register L |
| reg_f | input | 8 | Flag register |
| io_addr | output | 16 | Port address |
| io_wdata | output | 8 | Data for a port write |
| io_rd | output | 1 | Port read request |
| io_wr | output | 1 | Port write request |
| io_ack | input | 1 | Access acknowledge |
| io_rdata | input | 8 | Data returned by a port read, valid with `io_ack` |
| done | output | 1 | Instruction complete pulse |
| not_mine | output | 1 | Opcode refused pulse |
| wb_en | output | 1 | Register write-back strobe |
| wb_sel | output | 3 | Register code to write |
| wb_data | output | 8 | Register write-back value |
| flag_we | output | 1 | Flag write-back strobe |
| flag_data | output | 8 | New flag register value |

## Verification
The hold and drop checks on the handshake rely on `io_ack` being a single-cycle pulse that comes only while a strobe is up. The bench's responder raises it for exactly one cycle after the strobe has been seen for a chosen number of cycles, and lowers it at once. The assertions also expect the register snapshot and opcode bytes to be sampled only at `start`. The bench drives `start` for a single cycle and changes the register values only between instructions, except for a deliberate extra `start` during a busy instruction.

// File: rtl/port_io_pkg.sv
package port_io_pkg;

  localparam logic [7:0] OPC_IN_IMM  = 8'hDB;
  localparam logic [7:0] OPC_OUT_IMM = 8'hD3;
  localparam logic [7:0] OPC_PREFIX  = 8'hED;

  localparam logic [2:0] RCODE_FLAGS = 3'b110;
  localparam logic [2:0] RCODE_ACC   = 3'b111;

  // flag bit positions
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_H  = 4;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  // bits kept from the old flags: 5, 3 and carry
  localparam logic [7:0] FLAG_KEEP = 8'b0010_1001;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_TAIL   = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       ok;        // opcode is handled here
    logic       dir_in;    // 1 = port read
    logic       long_form; // prefixed register-port form
    logic [2:0] rcode;     // register code
  } dec_t;

endpackage

// File: rtl/port_io_decode.sv
module port_io_decode
  import port_io_pkg::*;
(
  input  logic [7:0] op0,
  input  logic [7:0] op1,
  output dec_t       dec
);

  logic pfx_match;

  // second byte of the prefixed forms: 01 rrr 00d
  assign pfx_match = (op1[7:6] == 2'b01) && (op1[2:1] == 2'b00);

  always_comb begin
    dec = '0;
    if (op0 == OPC_IN_IMM) begin
      dec.ok     = 1'b1;
      dec.dir_in = 1'b1;
      dec.rcode  = RCODE_ACC;
    end else if (op0 == OPC_OUT_IMM) begin
      dec.ok     = 1'b1;
      dec.dir_in = 1'b0;
      dec.rcode  = RCODE_ACC;
    end else if ((op0 == OPC_PREFIX) && pfx_match) begin
      dec.ok        = 1'b1;
      dec.long_form = 1'b1;
      dec.dir_in    = ~op1[0];
      dec.rcode     = op1[5:3];
    end
  end

endmodule

// File: rtl/port_io_flags.sv
module port_io_flags
  import port_io_pkg::*;
(
  input  logic [7:0] din,
  input  logic [7:0] f_old,
  output logic [7:0] f_new
);

  logic [7:0] fresh;

  always_comb begin
    fresh        = '0;
    fresh[FB_S]  = din[7];
    fresh[FB_Z]  = (din == 8'h00);
    fresh[FB_PV] = ~(^din);
    fresh[FB_H]  = 1'b0;
    fresh[FB_N]  = 1'b0;
    f_new        = (f_old & FLAG_KEEP) | (fresh & ~FLAG_KEEP);
  end

endmodule

// File: rtl/port_io_seq.sv
module port_io_seq
  import port_io_pkg::*;
#(
  parameter int CYC_IMM = 11,
  parameter int CYC_REG = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic long_form,
  input  logic io_ack,
  output logic idle,
  output logic io_active,
  output logic ack_take,
  output logic fin
);

  localparam int CYC_MAX = (CYC_REG > CYC_IMM) ? CYC_REG : CYC_IMM;
  localparam int CW      = $clog2(CYC_MAX + 1);
  localparam logic [CW-1:0] LIM_IMM = CW'(CYC_IMM - 1);
  localparam logic [CW-1:0] LIM_REG = CW'(CYC_REG - 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lim_d = lim_q;
    fin   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d  = ST_ACCESS;
          cnt_d = CW'(1);
          lim_d = long_form ? LIM_REG : LIM_IMM;
        end
      end
      ST_ACCESS: begin
        if (cnt_q < lim_q) cnt_d = cnt_q + CW'(1);
        if (io_ack) begin
          if (cnt_q >= lim_q) begin
            fin  = 1'b1;
            st_d = ST_IDLE;
          end else begin
            st_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (cnt_q >= lim_q) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign io_active = (st_q == ST_ACCESS);
  assign ack_take  = io_active & io_ack;

  // R7: the cycle counter never passes the budget of the running instruction
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (cnt_q <= lim_q));

  // R10: after the access has ended no second access starts within the instruction
  assert_tail_no_reaccess_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |=> (st_q != ST_ACCESS));

endmodule

// File: rtl/port_io_exec.sv
module port_io_exec
  import port_io_pkg::*;
#(
  parameter int CYC_IMM = 11,
  parameter int CYC_REG = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  op0,
  input  logic [7:0]  op1,
  input  logic [7:0]  reg_a,
  input  logic [7:0]  reg_b,
  input  logic [7:0]  reg_c,
  input  logic [7:0]  reg_d,
  input  logic [7:0]  reg_e,
  input  logic [7:0]  reg_h,
  input  logic [7:0]  reg_l,
  input  logic [7:0]  reg_f,
  output logic [15:0] io_addr,
  output logic [7:0]  io_wdata,
  output logic        io_rd,
  output logic        io_wr,
  input  logic        io_ack,
  input  logic [7:0]  io_rdata,
  output logic        done,
  output logic        not_mine,
  output logic        wb_en,
  output logic [2:0]  wb_sel,
  output logic [7:0]  wb_data,
  output logic        flag_we,
  output logic [7:0]  flag_data
);

  dec_t dec;
  logic idle, io_active, ack_take, fin, go;

  port_io_decode u_decode (
    .op0 (op0),
    .op1 (op1),
    .dec (dec)
  );

  assign go = start & idle & dec.ok;

  port_io_seq #(
    .CYC_IMM (CYC_IMM),
    .CYC_REG (CYC_REG)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .long_form (dec.long_form),
    .io_ack    (io_ack),
    .idle      (idle),
    .io_active (io_active),
    .ack_take  (ack_take),
    .fin       (fin)
  );

  // instruction context, loaded on go
  logic [15:0] addr_q, addr_d;
  logic [7:0]  wdat_q, wdat_d;
  logic        dirin_q, dirin_d;
  logic        setf_q, setf_d;
  logic [2:0]  rc_q, rc_d;
  logic [7:0]  fsnap_q, fsnap_d;
  logic [7:0]  rdat_q, rdat_d;
  logic [7:0]  src_byte;
  logic [7:0]  in_byte;
  logic [7:0]  f_calc;

  // source register for a write
  always_comb begin
    case (dec.rcode)
      3'b000:  src_byte = reg_b;
      3'b001:  src_byte = reg_c;
      3'b010:  src_byte = reg_d;
      3'b011:  src_byte = reg_e;
      3'b100:  src_byte = reg_h;
      3'b101:  src_byte = reg_l;
      3'b110:  src_byte = reg_f;
      default: src_byte = reg_a;
    endcase
  end

  always_comb begin
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    dirin_d = dirin_q;
    setf_d  = setf_q;
    rc_d    = rc_q;
    fsnap_d = fsnap_q;
    if (go) begin
      addr_d  = dec.long_form ? {reg_b, reg_c} : {reg_a, op1};
      wdat_d  = dec.dir_in ? 8'h00 : src_byte;
      dirin_d = dec.dir_in;
      setf_d  = dec.long_form & dec.dir_in;
      rc_d    = dec.rcode;
      fsnap_d = reg_f;
    end
  end

  assign rdat_d  = (ack_take && dirin_q) ? io_rdata : rdat_q;
  assign in_byte = rdat_d;

  port_io_flags u_flags (
    .din   (in_byte),
    .f_old (fsnap_q),
    .f_new (f_calc)
  );

  // registered result pulses
  logic       done_q, nm_q, wben_q, fwe_q;
  logic [2:0] wbsel_q;
  logic [7:0] wbdat_q, fdat_q;
  logic       done_d, nm_d, wben_d, fwe_d;
  logic [2:0] wbsel_d;
  logic [7:0] wbdat_d, fdat_d;

  always_comb begin
    done_d  = fin;
    nm_d    = start & idle & ~dec.ok;
    wben_d  = fin & dirin_q & (rc_q != RCODE_FLAGS);
    fwe_d   = fin & setf_q;
    wbsel_d = wbsel_q;
    wbdat_d = wbdat_q;
    fdat_d  = fdat_q;
    if (fin) begin
      wbsel_d = rc_q;
      wbdat_d = in_byte;
      fdat_d  = f_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdat_q  <= '0;
      dirin_q <= 1'b0;
      setf_q  <= 1'b0;
      rc_q    <= '0;
      fsnap_q <= '0;
      rdat_q  <= '0;
      done_q  <= 1'b0;
      nm_q    <= 1'b0;
      wben_q  <= 1'b0;
      fwe_q   <= 1'b0;
      wbsel_q <= '0;
      wbdat_q <= '0;
      fdat_q  <= '0;
    end else begin
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      dirin_q <= dirin_d;
      setf_q  <= setf_d;
      rc_q    <= rc_d;
      fsnap_q <= fsnap_d;
      rdat_q  <= rdat_d;
      done_q  <= done_d;
      nm_q    <= nm_d;
      wben_q  <= wben_d;
      fwe_q   <= fwe_d;
      wbsel_q <= wbsel_d;
      wbdat_q <= wbdat_d;
      fdat_q  <= fdat_d;
    end
  end

  assign io_addr   = addr_q;
  assign io_wdata  = wdat_q;
  assign io_rd     = io_active & dirin_q;
  assign io_wr     = io_active & ~dirin_q;
  assign done      = done_q;
  assign not_mine  = nm_q;
  assign wb_en     = wben_q;
  assign wb_sel    = wbsel_q;
  assign wb_data   = wbdat_q;
  assign flag_we   = fwe_q;
  assign flag_data = fdat_q;

  // R10: read and write strobes are exclusive
  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));

  // R8: an unanswered request holds strobe, address and data
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && !io_ack) |=>
      ((io_rd || io_wr) && $stable(io_addr) && $stable(io_wdata)));

  // R8: the strobe drops after the acknowledge edge
  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_ack) |=> !(io_rd || io_wr));

  // R9: a refused opcode causes no access and no completion
  assert_refuse_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    not_mine |-> (!done && !io_rd && !io_wr && !wb_en && !flag_we));

  // R6: code 110 never reaches the register write port; write-back only with done
  assert_no_f_regwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && (wb_sel != RCODE_FLAGS)));

  // R5: written flags always have H and N clear
  assert_hn_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (done && !flag_data[FB_H] && !flag_data[FB_N]));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/port_io_exec_tb.sv
`timescale 1ns/1ps
module port_io_exec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op0 = '0, op1 = '0;
  logic [7:0]  ra = '0, rb = '0, rc = '0, rd = '0, re = '0, rh = '0, rl = '0, rf = '0;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_rd, io_wr;
  logic        io_ack = 1'b0;
  logic [7:0]  io_rdata = '0;
  logic        done, not_mine, wb_en, flag_we;
  logic [2:0]  wb_sel;
  logic [7:0]  wb_data, flag_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  port_io_exec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op0(op0), .op1(op1),
    .reg_a(ra), .reg_b(rb), .reg_c(rc), .reg_d(rd), .reg_e(re),
    .reg_h(rh), .reg_l(rl), .reg_f(rf),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_ack(io_ack), .io_rdata(io_rdata),
    .done(done), .not_mine(not_mine), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_data(wb_data), .flag_we(flag_we), .flag_data(flag_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input logic [2:0] code);
    case (code)
      3'b000: return rb;
      3'b001: return rc;
      3'b010: return rd;
      3'b011: return re;
      3'b100: return rh;
      3'b101: return rl;
      3'b110: return rf;
      default: return ra;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_regs(input int s);
    ra = 8'(s * 7 + 3);   rb = 8'(s * 13 + 1); rc = 8'(s ^ 8'hA5);
    rd = 8'(s + 8'h40);   re = 8'(s * 3);      rh = 8'(~s);
    rl = 8'(s * 11 + 9);  rf = 8'(s * 5 + 2);
  endtask

  task automatic run(input logic [7:0] o0, input logic [7:0] o1,
                     input logic [7:0] dval, input int delay, input bit poke);
    bit          e_ok, e_in, e_wb, e_fw;
    logic [15:0] e_addr;
    logic [7:0]  e_wd, e_f;
    logic [2:0]  e_sel;
    int          e_len, edges, scnt, ack_at, rises, exp_edge;
    bit          seen_done, prev, nm;
    e_ok = 0; e_in = 0; e_wb = 0; e_fw = 0; e_addr = '0; e_wd = '0; e_sel = '0; e_len = 11;
    if (o0 == 8'hDB) begin
      e_ok = 1; e_in = 1; e_addr = {ra, o1}; e_wb = 1; e_sel = 3'b111;
    end else if (o0 == 8'hD3) begin
      e_ok = 1; e_in = 0; e_addr = {ra, o1}; e_wd = ra;
    end else if (o0 == 8'hED && o1[7:6] == 2'b01 && o1[2:1] == 2'b00) begin
      e_ok = 1; e_len = 12; e_addr = {rb, rc}; e_in = ~o1[0]; e_sel = o1[5:3];
      if (e_in) begin
        e_fw = 1; e_wb = (o1[5:3] != 3'b110);
      end else begin
        e_wd = reg_of(o1[5:3]);
      end
    end
    e_f = {dval[7], (dval == 8'h00), rf[5], 1'b0, rf[3], ~(^dval), 1'b0, rf[0]};

    @(negedge clk);
    start = 1'b1; op0 = o0; op1 = o1;
    @(negedge clk);
    start = 1'b0; edges = 1;

    if (!e_ok) begin
      check(not_mine == 1'b1, "R9", "not_mine pulse", not_mine, 1);
      for (int k = 0; k < 13; k++) begin
        check(!(io_rd || io_wr || done || wb_en || flag_we), "R9", "quiet after refuse",
              {io_rd, io_wr, done, wb_en, flag_we}, 0);
        @(negedge clk);
        if (k == 0) check(not_mine == 1'b0, "R9", "not_mine one cycle", not_mine, 0);
      end
      return;
    end

    seen_done = 0; scnt = 0; ack_at = -1; rises = 0; prev = 0; nm = 0;
    while (!seen_done && edges < 300) begin
      if (not_mine) nm = 1;
      start = (poke && edges == 2);
      if (poke && edges == 2) op0 = 8'h00;
      if (io_rd && io_wr) check(0, "R10", "rd and wr together", 3, 0);
      if ((io_rd || io_wr) && !prev) rises++;
      prev = io_rd || io_wr;
      if (io_ack) begin
        io_ack = 1'b0;
        check(!(io_rd || io_wr), "R8", "strobe after ack", {io_rd, io_wr}, 0);
      end else if (io_rd || io_wr) begin
        if (scnt == 0) begin
          check(io_rd == e_in && io_wr == !e_in, e_in ? "R1/R3" : "R2/R4", "direction",
                {io_rd, io_wr}, {e_in, !e_in});
          check(io_addr == e_addr, o0 == 8'hED ? "R3" : "R1", "address", io_addr, e_addr);
          if (!e_in) check(io_wdata == e_wd, o0 == 8'hED ? "R4" : "R2", "write data",
                           io_wdata, e_wd);
        end else begin
          check(io_addr == e_addr && (e_in || io_wdata == e_wd), "R8", "held request",
                io_addr, e_addr);
        end
        scnt++;
        if (scnt > delay) begin
          io_ack = 1'b1; io_rdata = dval; ack_at = edges;
        end
      end
      if (done) begin
        seen_done = 1;
        exp_edge = (e_len > ack_at + 1) ? e_len : ack_at + 1;
        check(edges == exp_edge, "R7", "done timing", edges, exp_edge);
        check(wb_en == e_wb, "R6", "wb_en", wb_en, e_wb);
        if (e_wb) begin
          check(wb_sel == e_sel, o0 == 8'hED ? "R3" : "R1", "wb_sel", wb_sel, e_sel);
          check(wb_data == dval, o0 == 8'hED ? "R3" : "R1", "wb_data", wb_data, dval);
        end
        check(flag_we == e_fw, "R1/R6", "flag_we", flag_we, e_fw);
        if (e_fw) check(flag_data == e_f, "R5", "flag value", flag_data, e_f);
      end else begin
        @(negedge clk);
        edges++;
      end
    end
    if (!seen_done) check(0, "R7", "done never came", edges, e_len);
    io_ack = 1'b0;
    start = 1'b0;
    check(rises == 1, "R10", "one access", rises, 1);
    check(nm == 0, "R11", "busy start refused pulse", nm, 0);
    @(negedge clk);
    check(!done && !wb_en && !flag_we, "R7", "pulse width", {done, wb_en, flag_we}, 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        check(!(io_rd || io_wr || done || not_mine), "R11", "busy start ignored",
              {io_rd, io_wr, done, not_mine}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!(io_rd || io_wr || done || not_mine || wb_en || flag_we), "R12", "in reset",
          {io_rd, io_wr, done, not_mine, wb_en, flag_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!(io_rd || io_wr || done || not_mine || wb_en || flag_we), "R12", "after reset",
          {io_rd, io_wr, done, not_mine, wb_en, flag_we}, 0);

    // first byte sweep (R1, R2, R9)
    for (int i = 0; i < 256; i++) begin
      set_regs(i);
      run(8'(i), 8'h78, 8'(i ^ 8'h5A), i % 3, 1'b0);
    end
    // prefixed second byte sweep (R3, R4, R6, R9)
    for (int j = 0; j < 256; j++) begin
      set_regs(j + 17);
      run(8'hED, 8'(j), 8'(j * 37), j % 4, 1'b0);
    end
    // flag sweep on every data value (R5, R6)
    for (int d = 0; d < 256; d++) begin
      set_regs(d);
      rf = 8'(~d);
      run(8'hED, 8'h70, 8'(d), 0, 1'b0);
    end
    // long waits (R7, R8)
    set_regs(99);
    run(8'hDB, 8'h12, 8'hC3, 25, 1'b0);
    run(8'hED, 8'h41, 8'h00, 15, 1'b0);
    run(8'hED, 8'h71, 8'h00, 9, 1'b0);
    // start while busy (R11)
    run(8'hDB, 8'h34, 8'h81, 0, 1'b1);
    run(8'hED, 8'h50, 8'h7E, 2, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule